// File: doc/BRIEF.md
# Buffered SPI Slave

This block is the slave end of an SPI link. An external master drives the serial clock and an active-low select line. The block samples the master's output data line and drives its own data line back. It never generates a clock and has no rate divider: the master's clock alone sets the bit rate. The select, serial clock and incoming data lines are brought into the system clock domain through two-flop synchronizers, and clock edges are detected there. Clock polarity, clock phase, bit order and frame length (8 or 16 bits) are set by four static configuration inputs, which must match the master.

The local host does not touch a shift register directly. It writes the next outgoing word into a one-word transmit holding register and reads each incoming word from a one-word receive holding register. Four flags report progress and errors: transmit empty, receive full, overrun and underrun. A combined interrupt line is also provided. A frame engine drives all of this with three enumerated states:
- `ST_IDLE`: select is high and the output is off.
- `ST_ARM`: select is low and the engine waits for a frame's first leading clock edge, while the data line shows a preview of the word about to be sent.
- `ST_SHIFT`: a frame is in progress.

The transitions are:
- IDLE to ARM when select falls.
- ARM to SHIFT on the first leading edge, which also loads the transmit word.
- SHIFT to ARM on the last sampling edge of a frame, so that frames can run back to back.
- Any state to IDLE when select rises.

Top module: `spi_tgt_buffered`

## Requirements
- R1: After reset, tx_empty_o=1, rx_full_o=0, overrun_o=0, underrun_o=0, irq_o=0, miso_oe_o=0 and miso_o=0.
- R2: While cs_n_i is high, miso_oe_o=0 and miso_o=0. Raising cs_n_i in the middle of a frame discards the partial word: rx_full_o stays unchanged and the next frame starts again at bit 0.
- R3: The leading SCK edge is rising when cfg_cpol=0 and falling when cfg_cpol=1. Data is sampled on the leading edge when cfg_cpha=0 and on the trailing edge when cfg_cpha=1. In all four modes, the word the host wrote reaches the master and the master's word reaches rd_data.
- R4: With cfg_lsb_first=1, bit 0 travels first in both directions. With cfg_lsb_first=0, the most significant bit of the frame travels first.
- R5: With cfg_frame16=1, frames are 16 bits long. With cfg_frame16=0, frames are 8 bits long: only wr_data[7:0] is sent, and rd_data[15:8] reads as zero.
- R6: The held transmit word moves to the shifter on the first leading SCK edge of a frame, not when select falls. tx_empty_o rises on that transfer. A write is accepted only while tx_empty_o=1; a write made while it is 0 is dropped.
- R7: After the final sampling edge of a frame, the received word appears on rd_data and rx_full_o rises. Asserting rd_en clears rx_full_o.
- R8: If a frame completes while rx_full_o=1 and no read occurs in the same cycle, overrun_o is set and rd_data keeps the earlier word. A read clears overrun_o.
- R9: If a frame starts while tx_empty_o=1, the block sends the last loaded word again (zero after reset) and sets underrun_o. An accepted write clears underrun_o.
- R10: irq_o is high exactly when rx_full_o, overrun_o or underrun_o is high.
- R11: When select stays low across several frames, each frame loads a fresh word written while the previous frame was running.
- R12: The bit rate follows the master's SCK alone. Operation is correct for any SCK half-period of at least 3 system clock cycles, and for select falling at least that long before the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| cs_n_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o |
| cfg_cpol | input | 1 | Idle level of SCK |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_frame16 | input | 1 | 1: 16-bit frames, 0: 8-bit frames |
| wr_en | input | 1 | Host write strobe for the transmit register |
| wr_data | input | DATA_W | Host word to send |
| rd_en | input | 1 | Host read strobe for the receive register |
| rd_data | output | DATA_W | Last received word |
| tx_empty_o | output | 1 | Transmit register can take a word |
| rx_full_o | output | 1 | Receive register holds an unread word |
| overrun_o | output | 1 | A received word was lost |
| underrun_o | output | 1 | A frame started with no new word |
| irq_o | output | 1 | OR of rx_full_o, overrun_o and underrun_o |

## Verification
Several rules are checked by assertions on every cycle:
- The flag updates in the holding registers: transmit-empty rising on a load, dropped writes, receive-full rising on completion, read clearing, overrun keeping the old word, and underrun being flagged.
- The return to idle on deselect.
- The frame counter staying inside the frame length.
- The minimum spacing of synchronized clock edges.

Other behaviour is visible only in the bench's scenarios, because it depends on the master's view of the wire. This covers the bit values exchanged in each clock mode, bit order and frame length, the load happening at the first edge rather than at select, the repeat of the stale word on underrun, realignment after an aborted frame, and back-to-back frames.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic lead;
        logic samp;
    } sck_evt_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int          N      = 3,
    parameter int          STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
            end
        end

        assign dout[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
    import spi_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_s,
    input  logic     cpol,
    input  logic     cpha,
    output sck_evt_t evt
);

    logic sck_q;
    logic rise;
    logic fall;
    logic trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else begin
            sck_q <= sck_s;
        end
    end

    always_comb begin
        rise     = sck_s & ~sck_q;
        fall     = ~sck_s & sck_q;
        evt.lead = cpol ? fall : rise;
        trail    = cpol ? rise : fall;
        evt.samp = cpha ? trail : evt.lead;
    end

    // Two edges in consecutive cycles would mean SCK is faster than the synchronizer can follow
    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> !(rise || fall)); // R12

endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  sck_evt_t          evt,
    input  logic              lsb_first,
    input  logic              frame16,
    input  logic [DATA_W-1:0] tx_hold,
    input  logic              tx_empty,
    output logic              load_o,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_word_o
);

    localparam int NARROW_W = DATA_W / 2;
    localparam int CNT_W    = $clog2(DATA_W);

    eng_state_t        state;
    eng_state_t        state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_idx;
    logic [CNT_W-1:0]  cur_pos;
    logic [CNT_W-1:0]  first_pos;
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] preview;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_merged;
    logic              sample;

    assign last_idx  = frame16 ? CNT_W'(DATA_W - 1) : CNT_W'(NARROW_W - 1);
    assign cur_pos   = lsb_first ? cnt : (last_idx - cnt);
    assign first_pos = lsb_first ? '0 : last_idx;
    assign preview   = tx_empty ? tx_word : tx_hold;

    assign load_o = (state == ST_ARM) && !cs_n_s && evt.lead;
    assign sample = !cs_n_s && evt.samp && ((state == ST_SHIFT) || load_o);

    always_comb begin
        rx_merged          = (cnt == '0) ? '0 : rx_sh;
        rx_merged[cur_pos] = mosi_s;
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!cs_n_s) state_nx = ST_ARM;
            ST_ARM: begin
                if (cs_n_s)        state_nx = ST_IDLE;
                else if (evt.lead) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_n_s)                             state_nx = ST_IDLE;
                else if (evt.samp && cnt == last_idx)   state_nx = ST_ARM;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Outputs per state
    always_comb begin
        miso_oe_o = 1'b0;
        miso_o    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                miso_oe_o = 1'b0;
            end
            ST_ARM: begin
                miso_oe_o = 1'b1;
                miso_o    = preview[first_pos];
            end
            ST_SHIFT: begin
                miso_oe_o = 1'b1;
                miso_o    = tx_word[cur_pos];
            end
            default: begin
                miso_oe_o = 1'b0;
            end
        endcase
    end

    // Frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            tx_word    <= '0;
            rx_sh      <= '0;
            rx_word_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (load_o) begin
                tx_word <= preview;
            end
            if (sample) begin
                rx_sh <= rx_merged;
                if (cnt == last_idx) begin
                    cnt        <= '0;
                    rx_word_o  <= rx_merged;
                    rx_valid_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (cs_n_s) begin
                cnt <= '0;
            end
        end
    end

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (state == ST_IDLE)); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (cnt <= last_idx)); // R5

    AST_NO_WORD_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !rx_valid_o); // R2

endmodule

// File: rtl/spi_tgt_hostbuf.sv
module spi_tgt_hostbuf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              load,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_word,
    output logic [DATA_W-1:0] tx_hold,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rx_hold,
    output logic              rx_full,
    output logic              overrun,
    output logic              underrun
);

    logic wr_take;

    assign wr_take = wr_en && tx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold  <= '0;
            tx_empty <= 1'b1;
            underrun <= 1'b0;
        end else begin
            if (wr_take) begin
                tx_hold  <= wr_data;
                tx_empty <= 1'b0;
                underrun <= 1'b0;
            end
            if (load) begin
                if (tx_empty) begin
                    underrun <= 1'b1;
                end else begin
                    tx_empty <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (rd_en) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
            end
            if (rx_valid) begin
                if (rx_full && !rd_en) begin
                    overrun <= 1'b1;
                end else begin
                    rx_hold <= rx_word;
                    rx_full <= 1'b1;
                end
            end
        end
    end

    AST_TXE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> tx_empty); // R6

    AST_WR_DROPPED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_empty) |=> $stable(tx_hold)); // R6

    AST_RXNE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_full); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rx_valid) |=> (!rx_full && !overrun)); // R7

    AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_full && !rd_en) |=> (overrun && $stable(rx_hold))); // R8

    AST_UDR_ON_EMPTY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tx_empty) |=> underrun); // R9

endmodule

// File: rtl/spi_tgt_buffered.sv
module spi_tgt_buffered
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_frame16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty_o,
    output logic              rx_full_o,
    output logic              overrun_o,
    output logic              underrun_o,
    output logic              irq_o
);

    logic [2:0]        pins_s;
    sck_evt_t          evt;
    logic              load;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_word;
    logic [DATA_W-1:0] tx_hold;

    // bit 2: sck, bit 1: select (idle high), bit 0: data in
    spi_tgt_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sck_i, cs_n_i, mosi_i}),
        .dout  (pins_s)
    );

    spi_tgt_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_s (pins_s[2]),
        .cpol  (cfg_cpol),
        .cpha  (cfg_cpha),
        .evt   (evt)
    );

    spi_tgt_engine #(
        .DATA_W (DATA_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .evt        (evt),
        .lsb_first  (cfg_lsb_first),
        .frame16    (cfg_frame16),
        .tx_hold    (tx_hold),
        .tx_empty   (tx_empty_o),
        .load_o     (load),
        .miso_o     (miso_o),
        .miso_oe_o  (miso_oe_o),
        .rx_valid_o (rx_valid),
        .rx_word_o  (rx_word)
    );

    spi_tgt_hostbuf #(
        .DATA_W (DATA_W)
    ) u_hostbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .load     (load),
        .rx_valid (rx_valid),
        .rx_word  (rx_word),
        .tx_hold  (tx_hold),
        .tx_empty (tx_empty_o),
        .rx_hold  (rd_data),
        .rx_full  (rx_full_o),
        .overrun  (overrun_o),
        .underrun (underrun_o)
    );

    assign irq_o = rx_full_o | overrun_o | underrun_o;

endmodule

// File: tb/spi_tgt_buffered_tb.sv
module spi_tgt_buffered_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        miso_oe;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        lsb = 1'b0;
    logic        wide = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        txe, rxne, ovr, udr, irq;

    int n_tests = 0;
    int n_fail  = 0;
    int half    = 8;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_tgt_buffered u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_i         (sck),
        .cs_n_i        (cs_n),
        .mosi_i        (mosi),
        .miso_o        (miso),
        .miso_oe_o     (miso_oe),
        .cfg_cpol      (cpol),
        .cfg_cpha      (cpha),
        .cfg_lsb_first (lsb),
        .cfg_frame16   (wide),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_en         (rd_en),
        .rd_data       (rd_data),
        .tx_empty_o    (txe),
        .rx_full_o     (rxne),
        .overrun_o     (ovr),
        .underrun_o    (udr),
        .irq_o         (irq)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int bidx(input int k, input int n);
        return lsb ? k : (n - 1 - k);
    endfunction

    task automatic set_mode(input logic p, input logic h, input logic l, input logic w);
        cpol = p; cpha = h; lsb = l; wide = w;
        sck  = p;
        wait_clk(6);
    endtask

    task automatic host_write(input logic [15:0] d);
        wr_data = d; wr_en = 1'b1;
        wait_clk(1);
        wr_en = 1'b0;
    endtask

    task automatic host_read(output logic [15:0] d);
        d = rd_data; rd_en = 1'b1;
        wait_clk(1);
        rd_en = 1'b0;
    endtask

    // Master side of one frame: nbits clocks, optional select handling
    task automatic spi_xfer(input logic [15:0] mo, output logic [15:0] mi,
                            input int nbits, input bit start, input bit keep);
        mi = '0;
        if (start) cs_n = 1'b0;
        if (!cpha) mosi = mo[bidx(0, nbits)];
        wait_clk(half);
        for (int k = 0; k < nbits; k++) begin
            if (!cpha) begin
                mi[bidx(k, nbits)] = miso;
                sck = ~cpol;
                wait_clk(half);
                sck = cpol;
                if (k < nbits - 1) mosi = mo[bidx(k + 1, nbits)];
                wait_clk(half);
            end else begin
                sck  = ~cpol;
                mosi = mo[bidx(k, nbits)];
                wait_clk(half);
                mi[bidx(k, nbits)] = miso;
                sck = cpol;
                wait_clk(half);
            end
        end
        if (!keep) begin
            cs_n = 1'b1;
            wait_clk(half);
        end
    endtask

    task automatic t_reset;
        chk("R1", "tx_empty", txe, 1);
        chk("R1", "rx_full", rxne, 0);
        chk("R1", "flags ovr/udr/irq", {ovr, udr, irq}, 0);
        chk("R1", "miso oe/val", {miso_oe, miso}, 0);
    endtask

    task automatic t_modes;
        logic [15:0] got, r;
        for (int m = 0; m < 4; m++) begin
            logic [15:0] hw, mw;
            hw = 16'hA35C ^ (16'h1111 * m);
            mw = 16'h6E91 + (16'h0F0F * m);
            set_mode(m[1], m[0], 1'b0, 1'b1);
            host_write(hw);
            chk("R6", "tx_empty after write", txe, 0);
            spi_xfer(mw, got, 16, 1, 0);
            wait_clk(4);
            chk("R3", $sformatf("mode %0d master got", m), got, hw);
            chk("R7", $sformatf("mode %0d rd_data", m), rd_data, mw);
            chk("R7", "rx_full set", rxne, 1);
            chk("R6", "tx_empty after frame", txe, 1);
            host_read(r);
            chk("R7", "rx_full cleared by read", rxne, 0);
        end
    endtask

    task automatic t_order_width;
        logic [15:0] got, r;
        set_mode(1'b0, 1'b0, 1'b1, 1'b1);
        host_write(16'h8001);
        spi_xfer(16'h00F3, got, 16, 1, 0);
        wait_clk(4);
        chk("R4", "lsb16 master got", got, 16'h8001);
        chk("R4", "lsb16 rd_data", rd_data, 16'h00F3);
        host_read(r);
        set_mode(1'b0, 1'b1, 1'b0, 1'b0);
        host_write(16'hFF5A);
        spi_xfer(16'hBE3C, got, 8, 1, 0);
        wait_clk(4);
        chk("R5", "msb8 master got", got, 16'h005A);
        chk("R5", "msb8 rd_data upper zero", rd_data, 16'h003C);
        host_read(r);
        set_mode(1'b1, 1'b1, 1'b1, 1'b0);
        host_write(16'h12C1);
        spi_xfer(16'h0081, got, 8, 1, 0);
        wait_clk(4);
        chk("R4", "lsb8 master got", got, 16'h00C1);
        chk("R5", "lsb8 rd_data", rd_data, 16'h0081);
        host_read(r);
    endtask

    task automatic t_load_timing;
        logic [15:0] got, r;
        set_mode(1'b0, 1'b0, 1'b0, 1'b1);
        host_write(16'hC0DE);
        host_write(16'h1234);
        chk("R6", "write while full dropped (still full)", txe, 0);
        cs_n = 1'b0;
        wait_clk(half);
        chk("R6", "no load at select", txe, 0);
        chk("R2", "oe while selected", miso_oe, 1);
        chk("R6", "preview bit on miso", miso, 1);
        spi_xfer(16'h5555, got, 16, 0, 0);
        wait_clk(4);
        chk("R6", "first written word sent", got, 16'hC0DE);
        host_read(r);
        chk("R7", "read data", r, 16'h5555);
    endtask

    task automatic t_overrun;
        logic [15:0] got, r;
        set_mode(1'b0, 1'b0, 1'b0, 1'b1);
        host_write(16'h0A0A);
        spi_xfer(16'h1357, got, 16, 1, 0);
        host_write(16'h0B0B);
        spi_xfer(16'h2468, got, 16, 1, 0);
        wait_clk(4);
        chk("R8", "overrun set", ovr, 1);
        chk("R8", "old word kept", rd_data, 16'h1357);
        chk("R10", "irq on overrun", irq, 1);
        host_read(r);
        chk("R8", "read clears overrun", {ovr, rxne}, 0);
        chk("R10", "irq low when clear", irq, 0);
    endtask

    task automatic t_underrun;
        logic [15:0] got, r;
        set_mode(1'b1, 1'b0, 1'b0, 1'b1);
        host_write(16'h7E81);
        spi_xfer(16'h0001, got, 16, 1, 0);
        host_read(r);
        chk("R9", "no underrun with data", udr, 0);
        spi_xfer(16'h0002, got, 16, 1, 0);
        wait_clk(4);
        chk("R9", "stale word repeated", got, 16'h7E81);
        chk("R9", "underrun flagged", udr, 1);
        host_read(r);
        chk("R10", "irq held by underrun", irq, 1);
        host_write(16'h3C3C);
        chk("R9", "write clears underrun", udr, 0);
        chk("R10", "irq clear", irq, 0);
        spi_xfer(16'h0003, got, 16, 1, 0);
        wait_clk(4);
        chk("R9", "fresh word after underrun", got, 16'h3C3C);
        host_read(r);
    endtask

    task automatic t_abort;
        logic [15:0] got, r;
        set_mode(1'b0, 1'b1, 1'b0, 1'b1);
        host_write(16'hDEAD);
        spi_xfer(16'hFFFF, got, 3, 1, 0);
        wait_clk(4);
        chk("R2", "partial frame discarded", rxne, 0);
        chk("R2", "miso off when deselected", {miso_oe, miso}, 0);
        host_write(16'h4B1D);
        spi_xfer(16'h9A0C, got, 16, 1, 0);
        wait_clk(4);
        chk("R2", "realigned master got", got, 16'h4B1D);
        chk("R2", "realigned rd_data", rd_data, 16'h9A0C);
        host_read(r);
    endtask

    task automatic t_back_to_back;
        logic [15:0] g1, g2, r1, r2;
        set_mode(1'b0, 1'b0, 1'b0, 1'b1);
        host_write(16'hF00D);
        fork
            begin
                spi_xfer(16'h1A2B, g1, 16, 1, 1);
                spi_xfer(16'h3C4D, g2, 16, 0, 0);
            end
            begin
                wait (txe == 1'b1);
                @(negedge clk);
                host_write(16'hBEEF);
                wait (rxne == 1'b1);
                @(negedge clk);
                host_read(r1);
            end
        join
        wait_clk(4);
        host_read(r2);
        chk("R11", "frame1 master got", g1, 16'hF00D);
        chk("R11", "frame2 master got", g2, 16'hBEEF);
        chk("R11", "frame1 rx", r1, 16'h1A2B);
        chk("R11", "frame2 rx", r2, 16'h3C4D);
        chk("R11", "no errors", {ovr, udr}, 0);
    endtask

    task automatic t_rate;
        logic [15:0] got, r;
        half = 3;
        for (int m = 0; m < 4; m += 3) begin
            set_mode(m[1], m[0], 1'b0, 1'b1);
            host_write(16'h6D29 + 16'(m));
            spi_xfer(16'hE417 - 16'(m), got, 16, 1, 0);
            wait_clk(4);
            chk("R12", $sformatf("fast sck mode %0d master got", m), got, 16'h6D29 + 16'(m));
            chk("R12", $sformatf("fast sck mode %0d rd_data", m), rd_data, 16'hE417 - 16'(m));
            host_read(r);
        end
        half = 8;
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_modes();
        t_order_width();
        t_load_timing();
        t_overrun();
        t_underrun();
        t_abort();
        t_back_to_back();
        t_rate();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule